// File: doc/BRIEF.md
# General-Purpose Pin Controller with Hardware-Function Routing

This block controls a bank of general-purpose pins through a 32-bit register port. Software decides for each pin whether the input is seen and whether the output driver is enabled, and what value the pin drives. Software can also give a pin to one of two on-chip hardware functions. A routing stage then takes the output value and the drive enable from that function in place of the registers. After the routing stage, a per-pin inversion mask flips the driven level.

Pad inputs pass through a two-stage synchronizer. The synchronized level feeds the readable input value, the hardware functions' input ports, and four interrupt detectors per pin: rising edge, falling edge, level high and level low. Each detector sets a sticky pending bit. Software clears a pending bit by writing a one to it. A per-class enable mask decides which pending bits reach the per-pin interrupt output.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset every control and enable register reads zero, `pad_oe`, `pad_out`, `irq` and `rsp_rdata` are zero, and the rise, fall and high pending registers read zero.
- R2: The register at word offset 0x00 returns the synchronized pad level ANDed with the input-enable mask (0x04). A pad change becomes visible to reads issued two clock edges later, and writes to 0x00 have no effect.
- R3: The registers at 0x04 (input enable), 0x08 (output enable), 0x0C (output value), 0x10 (function enable), 0x14 (function select, 0 = function 0, 1 = function 1), 0x18 (output inversion) and the interrupt enables read back what was written, in the low N bits with zeros above. An access whose address bits [1:0] are not zero changes nothing and reads zero. An unmapped word reads zero.
- R4: A rising edge of a synchronized input sets bit i of the rise pending register (0x24). The rise enable register is at 0x20.
- R5: A falling edge sets bit i of the fall pending register (0x2C). The fall enable register is at 0x28.
- R6: A high synchronized level sets bit i of the high pending register (0x34) in every cycle it lasts. The high enable register is at 0x30.
- R7: A low synchronized level sets bit i of the low pending register (0x3C) in every cycle it lasts. The low enable register is at 0x38.
- R8: A pending bit stays set until a write with a one in that position. Writing zero leaves it set. If the condition is still present, the set wins over the clear.
- R9: `irq[i]` is the OR over the four classes of (pending AND enable) for pin i.
- R10: When a pin's function-enable bit is 0, `pad_oe[i]` equals the output-enable bit and `pad_out[i]` equals the output-value bit XOR the inversion bit.
- R11: When function enable is 1 and the selected function exists on that pin, `pad_out[i]` is that function's output value XOR the inversion bit. If that function controls the driver, `pad_oe[i]` is also the function's output enable.
- R12: If the selected function does not control the driver on a pin, `pad_oe[i]` stays with the output-enable register. If the selected function does not exist on the pin, the pin stays under full register control as in R10.
- R13: `fn0_in[i]` (`fn1_in[i]`) carries the gated input value of R2 only while pin i is routed to function 0 (1), and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| pad_in | input | N | Raw pad levels |
| pad_out | output | N | Driven pad levels |
| pad_oe | output | N | Pad driver enables |
| fn0_out | input | N | Function 0 output values |
| fn0_oe | input | N | Function 0 driver enables |
| fn0_in | output | N | Input values for function 0 |
| fn1_out | input | N | Function 1 output values |
| fn1_oe | input | N | Function 1 driver enables |
| fn1_in | output | N | Input values for function 1 |
| irq | output | N | Per-pin interrupt |

## Verification
Register writes take effect at the clock edge that accepts them. The pad outputs and `irq` are combinational from the registers, so the bench samples them at the falling edge after a write completes. Read data is registered and is sampled one full cycle after the request. A pad change needs two edges to reach the synchronized value and a third to set a pending bit. The bench therefore waits four cycles after each pad change before it reads the value or a pending register, so every sample falls after the result is due.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int BUS_W = 32;

    // interrupt classes, also their order in the register map
    localparam int NCLS     = 4;
    localparam int CLS_RISE = 0;
    localparam int CLS_FALL = 1;
    localparam int CLS_HIGH = 2;
    localparam int CLS_LOW  = 3;

    // word indices (byte offset / 4)
    localparam int IDX_VALUE    = 0;
    localparam int IDX_IN_EN    = 1;
    localparam int IDX_OUT_EN   = 2;
    localparam int IDX_OUT_VAL  = 3;
    localparam int IDX_FN_EN    = 4;
    localparam int IDX_FN_SEL   = 5;
    localparam int IDX_OUT_INV  = 6;
    // class c: enable at CLS_BASE + 2c, pending at CLS_BASE + 2c + 1
    localparam int IDX_CLS_BASE = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_mux_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             level_i,
    input  logic [NCLS-1:0][N-1:0]   clr_i,
    input  logic [NCLS-1:0][N-1:0]   en_i,
    output logic [NCLS-1:0][N-1:0]   pend_o,
    output logic [N-1:0]             irq_o
);
    typedef struct packed {
        logic [NCLS-1:0][N-1:0] pend;
        logic [N-1:0]           prev;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [NCLS-1:0][N-1:0] cond;

    always_comb begin
        cond[CLS_RISE] = level_i & ~st_q.prev;
        cond[CLS_FALL] = ~level_i & st_q.prev;
        cond[CLS_HIGH] = level_i;
        cond[CLS_LOW]  = ~level_i;

        st_d      = st_q;
        st_d.prev = level_i;
        irq_o     = '0;
        for (int c = 0; c < NCLS; c++) begin
            // a condition present this cycle wins over a clear
            st_d.pend[c] = (st_q.pend[c] & ~clr_i[c]) | cond[c];
            irq_o        = irq_o | (st_q.pend[c] & en_i[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R8
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_q.pend & $past(st_q.pend & ~clr_i)) == '0));

    // R4
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(cond)) == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int           N            = 32,
    parameter logic [N-1:0] FN0_PRESENT  = '1,
    parameter logic [N-1:0] FN1_PRESENT  = '1,
    parameter logic [N-1:0] FN0_OE_DRIVE = '1,
    parameter logic [N-1:0] FN1_OE_DRIVE = '1
) (
    input  logic [N-1:0] out_val_i,
    input  logic [N-1:0] out_en_i,
    input  logic [N-1:0] out_inv_i,
    input  logic [N-1:0] fn_en_i,
    input  logic [N-1:0] fn_sel_i,
    input  logic [N-1:0] in_val_i,
    input  logic [N-1:0] fn0_out_i,
    input  logic [N-1:0] fn0_oe_i,
    input  logic [N-1:0] fn1_out_i,
    input  logic [N-1:0] fn1_oe_i,
    output logic [N-1:0] pad_out_o,
    output logic [N-1:0] pad_oe_o,
    output logic [N-1:0] fn0_in_o,
    output logic [N-1:0] fn1_in_o
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic use0, use1, val, oe;

        if (FN0_PRESENT[i]) begin : g_f0
            assign use0 = fn_en_i[i] & ~fn_sel_i[i];
        end else begin : g_nf0
            assign use0 = 1'b0;
        end

        if (FN1_PRESENT[i]) begin : g_f1
            assign use1 = fn_en_i[i] & fn_sel_i[i];
        end else begin : g_nf1
            assign use1 = 1'b0;
        end

        always_comb begin
            val = out_val_i[i];
            oe  = out_en_i[i];
            if (use0) begin
                val = fn0_out_i[i];
                if (FN0_OE_DRIVE[i]) oe = fn0_oe_i[i];
            end else if (use1) begin
                val = fn1_out_i[i];
                if (FN1_OE_DRIVE[i]) oe = fn1_oe_i[i];
            end
        end

        assign pad_out_o[i] = val ^ out_inv_i[i];
        assign pad_oe_o[i]  = oe;
        assign fn0_in_o[i]  = use0 & in_val_i[i];
        assign fn1_in_o[i]  = use1 & in_val_i[i];
    end
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
    import gpio_mux_pkg::*;
#(
    parameter int           N            = 32,
    parameter int           ADDR_W       = 8,
    parameter int           SYNC_STAGES  = 2,
    parameter logic [N-1:0] FN0_PRESENT  = '1,
    parameter logic [N-1:0] FN1_PRESENT  = '1,
    parameter logic [N-1:0] FN0_OE_DRIVE = '1,
    parameter logic [N-1:0] FN1_OE_DRIVE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    input  logic [N-1:0]      fn0_out,
    input  logic [N-1:0]      fn0_oe,
    output logic [N-1:0]      fn0_in,
    input  logic [N-1:0]      fn1_out,
    input  logic [N-1:0]      fn1_oe,
    output logic [N-1:0]      fn1_in,
    output logic [N-1:0]      irq
);
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [N-1:0]           in_en;
        logic [N-1:0]           out_en;
        logic [N-1:0]           out_val;
        logic [N-1:0]           fn_en;
        logic [N-1:0]           fn_sel;
        logic [N-1:0]           out_inv;
        logic [NCLS-1:0][N-1:0] ien;
        logic [BUS_W-1:0]       rdata;
    } regs_t;

    regs_t q, d;

    logic [N-1:0]           level;
    logic [N-1:0]           in_val;
    logic [NCLS-1:0][N-1:0] pend;
    logic [NCLS-1:0][N-1:0] clr;
    logic [WORD_W-1:0]      word;
    logic                   aligned, wr_ok, rd_ok;
    logic [N-1:0]           wd;
    logic [N-1:0]           rv;

    gpio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(level)
    );

    assign in_val = level & q.in_en;

    always_comb begin
        word    = req_addr[ADDR_W-1:2];
        aligned = (req_addr[1:0] == 2'b00);
        wr_ok   = req_valid & req_write & aligned;
        rd_ok   = req_valid & ~req_write & aligned;
        wd      = req_wdata[N-1:0];

        d   = q;
        clr = '0;
        rv  = '0;

        if (wr_ok) begin
            case (int'(word))
                IDX_IN_EN:   d.in_en   = wd;
                IDX_OUT_EN:  d.out_en  = wd;
                IDX_OUT_VAL: d.out_val = wd;
                IDX_FN_EN:   d.fn_en   = wd;
                IDX_FN_SEL:  d.fn_sel  = wd;
                IDX_OUT_INV: d.out_inv = wd;
                default: ;
            endcase
        end

        case (int'(word))
            IDX_VALUE:   rv = in_val;
            IDX_IN_EN:   rv = q.in_en;
            IDX_OUT_EN:  rv = q.out_en;
            IDX_OUT_VAL: rv = q.out_val;
            IDX_FN_EN:   rv = q.fn_en;
            IDX_FN_SEL:  rv = q.fn_sel;
            IDX_OUT_INV: rv = q.out_inv;
            default: ;
        endcase

        for (int c = 0; c < NCLS; c++) begin
            if (int'(word) == IDX_CLS_BASE + 2*c) begin
                rv = q.ien[c];
                if (wr_ok) d.ien[c] = wd;
            end
            if (int'(word) == IDX_CLS_BASE + 2*c + 1) begin
                rv = pend[c];
                if (wr_ok) clr[c] = wd;
            end
        end

        d.rdata = rd_ok ? BUS_W'(rv) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_rdata = q.rdata;

    gpio_irq_unit #(.N(N)) u_irq (
        .clk(clk), .rst_n(rst_n), .level_i(level), .clr_i(clr),
        .en_i(q.ien), .pend_o(pend), .irq_o(irq)
    );

    gpio_pad_mux #(
        .N(N), .FN0_PRESENT(FN0_PRESENT), .FN1_PRESENT(FN1_PRESENT),
        .FN0_OE_DRIVE(FN0_OE_DRIVE), .FN1_OE_DRIVE(FN1_OE_DRIVE)
    ) u_mux (
        .out_val_i(q.out_val), .out_en_i(q.out_en), .out_inv_i(q.out_inv),
        .fn_en_i(q.fn_en), .fn_sel_i(q.fn_sel), .in_val_i(in_val),
        .fn0_out_i(fn0_out), .fn0_oe_i(fn0_oe),
        .fn1_out_i(fn1_out), .fn1_oe_i(fn1_oe),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .fn0_in_o(fn0_in), .fn1_in_o(fn1_in)
    );

    // R3
    misaligned_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[1:0] != 2'b00) |=> (rsp_rdata == '0));

    // R10
    sw_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q.fn_en & (pad_oe ^ q.out_en)) == '0));

    // R10
    sw_out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q.fn_en & (pad_out ^ q.out_val ^ q.out_inv)) == '0));
endmodule

// File: tb/sim_gpio_mux_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_mux_ctrl;
    localparam int           NP = 8;
    localparam logic [NP-1:0] P0 = 8'hFF;
    localparam logic [NP-1:0] P1 = 8'h0F;
    localparam logic [NP-1:0] D0 = 8'hF0;
    localparam logic [NP-1:0] D1 = 8'hFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0, rsp_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic [NP-1:0] fn0_out = '0, fn0_oe = '0, fn0_in;
    logic [NP-1:0] fn1_out = '0, fn1_oe = '0, fn1_in, irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_mux_ctrl #(
        .N(NP), .ADDR_W(8), .SYNC_STAGES(2),
        .FN0_PRESENT(P0), .FN1_PRESENT(P1),
        .FN0_OE_DRIVE(D0), .FN1_OE_DRIVE(D1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .fn0_out(fn0_out), .fn0_oe(fn0_oe), .fn0_in(fn0_in),
        .fn1_out(fn1_out), .fn1_oe(fn1_oe), .fn1_in(fn1_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        v = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check("R1 pad_oe", 32'(pad_oe), 0);
        check("R1 pad_out", 32'(pad_out), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 rsp_rdata", rsp_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 4; a <= 8'h18; a += 4) begin
            rd(8'(a), v); check("R1 ctrl reg", v, 0);
        end
        for (int c = 0; c < 4; c++) begin
            rd(8'(8'h20 + 8*c), v); check("R1 enable reg", v, 0);
        end
        rd(8'h24, v); check("R1 rise pend", v, 0);
        rd(8'h2C, v); check("R1 fall pend", v, 0);
        rd(8'h34, v); check("R1 high pend", v, 0);

        // R3 readback of every writable register
        for (int a = 4; a <= 8'h38; a += 4) begin
            if (a == 8'h1C || (a >= 8'h20 && (a % 8) == 4)) continue;
            wr(8'(a), 32'hFFFF_FF00 | 32'(a * 7 + 5));
            rd(8'(a), v); check("R3 readback", v, 32'((a * 7 + 5) & 8'hFF));
            wr(8'(a), 0);
        end
        wr(8'h04, 32'h3C);
        wr(8'h05, 32'hFF);
        rd(8'h04, v); check("R3 misaligned write ignored", v, 32'h3C);
        rd(8'h06, v); check("R3 misaligned read zero", v, 0);
        rd(8'h1C, v); check("R3 unmapped read zero", v, 0);
        rd(8'h7C, v); check("R3 unmapped high read zero", v, 0);

        // R2 input value gated by input enable
        for (int p = 0; p < 256; p += 17) begin
            pad_in = 8'(p);
            settle();
            rd(8'h00, v); check("R2 value", v, 32'(p & 8'h3C));
        end
        wr(8'h00, 32'hFF);
        rd(8'h00, v); check("R2 value write ignored", v, 32'(8'hFF & 8'h3C));

        // R4..R8 pending behaviour
        pad_in = 8'h00;
        settle();
        wr(8'h24, 32'hFF); wr(8'h2C, 32'hFF); wr(8'h34, 32'hFF); wr(8'h3C, 32'hFF);
        rd(8'h24, v); check("R4 rise cleared", v, 0);
        rd(8'h2C, v); check("R5 fall cleared", v, 0);
        rd(8'h34, v); check("R6 high cleared", v, 0);
        rd(8'h3C, v); check("R8 low set wins over clear", v, 32'hFF);
        pad_in = 8'h5A;
        settle();
        rd(8'h24, v); check("R4 rise pend", v, 32'h5A);
        rd(8'h2C, v); check("R5 no fall on rise", v, 0);
        rd(8'h34, v); check("R6 high pend", v, 32'h5A);
        wr(8'h3C, 32'hFF);
        rd(8'h3C, v); check("R7 low pend", v, 32'hA5);
        pad_in = 8'h00;
        settle();
        rd(8'h2C, v); check("R5 fall pend", v, 32'h5A);
        rd(8'h24, v); check("R8 rise sticky", v, 32'h5A);
        rd(8'h34, v); check("R8 high sticky", v, 32'h5A);
        wr(8'h24, 32'h0F);
        rd(8'h24, v); check("R8 partial clear", v, 32'h50);
        wr(8'h24, 32'h00);
        rd(8'h24, v); check("R8 zero write keeps", v, 32'h50);

        // R9 interrupt output
        wr(8'h20, 32'h10);
        @(negedge clk); check("R9 irq rise", 32'(irq), 32'h10);
        wr(8'h28, 32'h02);
        @(negedge clk); check("R9 irq rise|fall", 32'(irq), 32'h12);
        wr(8'h24, 32'hFF);
        @(negedge clk); check("R9 irq after clear", 32'(irq), 32'h02);
        wr(8'h38, 32'h80);
        @(negedge clk); check("R9 irq low", 32'(irq), 32'h82);
        wr(8'h28, 0); wr(8'h38, 0); wr(8'h20, 0);
        @(negedge clk); check("R9 irq disabled", 32'(irq), 0);

        // R10..R13 routing sweep
        for (int k = 0; k < 96; k++) begin
            logic [NP-1:0] fe, fs, ov, oe, iv, ie, eo, ee, e0, e1;
            fe = 8'(k * 29 + 3);
            fs = 8'(k * 83 + 17);
            ov = 8'(k * 41 + 9);
            oe = 8'(k * 13 + 101);
            iv = 8'(k * 97 + 55);
            ie = 8'(k * 71 + 2);
            pad_in  = 8'(k * 53 + 7);
            fn0_out = 8'(k * 37);
            fn0_oe  = 8'(k * 61 + 11);
            fn1_out = 8'(k * 19 + 200);
            fn1_oe  = 8'(k * 5 + 77);
            wr(8'h04, 32'(ie)); wr(8'h08, 32'(oe)); wr(8'h0C, 32'(ov));
            wr(8'h10, 32'(fe)); wr(8'h14, 32'(fs)); wr(8'h18, 32'(iv));
            @(negedge clk);
            for (int i = 0; i < NP; i++) begin
                logic u0b, u1b;
                u0b = fe[i] & ~fs[i] & P0[i];
                u1b = fe[i] & fs[i] & P1[i];
                eo[i] = (u0b ? fn0_out[i] : u1b ? fn1_out[i] : ov[i]) ^ iv[i];
                ee[i] = (u0b && D0[i]) ? fn0_oe[i] : (u1b && D1[i]) ? fn1_oe[i] : oe[i];
                e0[i] = u0b & pad_in[i] & ie[i];
                e1[i] = u1b & pad_in[i] & ie[i];
            end
            if (fe == 0) begin
                check("R10 pad_out sw", 32'(pad_out), 32'(eo));
                check("R10 pad_oe sw", 32'(pad_oe), 32'(ee));
            end
            check("R11 pad_out", 32'(pad_out), 32'(eo));
            check("R12 pad_oe", 32'(pad_oe), 32'(ee));
            check("R13 fn0_in", 32'(fn0_in), 32'(e0));
            check("R13 fn1_in", 32'(fn1_in), 32'(e1));
        end
        // R10 explicit software-only pattern
        wr(8'h10, 0); wr(8'h0C, 32'hC3); wr(8'h18, 32'h0F); wr(8'h08, 32'h99);
        @(negedge clk);
        check("R10 pad_out", 32'(pad_out), 32'hCC);
        check("R10 pad_oe", 32'(pad_oe), 32'h99);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule